// File: doc/BRIEF.md
# Rotate-Mask and Shift Unit

This block is the bit-manipulation datapath of a 32-bit integer pipeline. Several operations share it. It can rotate a source word left and then clear everything outside a contiguous mask. It can rotate and then merge the masked bits into a destination word. It also performs logical shifts in both directions, an arithmetic right shift that reports a carry, a count of leading zeros, and sign extension of a byte or a halfword. The mask is given as a begin index and an end index. These indices count from the most significant bit, so index 0 is the top bit. When begin is greater than end, the mask wraps around the word.

The shift or rotate amount comes either from a 5-bit immediate or from the low 6 bits of a register operand. The result and its flags are captured in one output register. A value presented on one clock edge therefore appears on the outputs after that edge. The zero and negative flags describe the registered result and are meant for a condition-field update. The carry flag is meaningful only for the arithmetic shift.

Top module: `rmsu_top`

## Requirements
- R1: While rst_n is low at a rising clock edge, the outputs are cleared after that edge: result 0, carry 0, zero 0, negative 0.
- R2: Op code 0 (rotate-and-mask) rotates src_i left by the amount and keeps only the bits from mask begin through mask end, where index 0 is bit 31 and index 31 is bit 0; all other bits are zero. A rotate by 8 with mask 24..31 yields the low byte of the rotated word, and an amount of 0 passes the source through unchanged.
- R3: When mask begin is greater than mask end, the mask covers indices from begin up to 31 and from 0 up to end.
- R4: Op code 1 (rotate-and-insert) places the rotated, masked bits into dst_i and leaves dst_i bits outside the mask unchanged.
- R5: With amt_sel_i=1 the amount is reg_amt_i[5:0] and higher bits are ignored; with amt_sel_i=0 it is imm_amt_i. For rotates, only the low 5 bits of the amount count. An amount of 32 or more gives 0 for the logical shifts and a word filled with the sign bit for the arithmetic shift.
- R6: Op codes 2 (shift left) and 3 (logical shift right) fill vacated positions with zeros and discard bits shifted out.
- R7: Op code 4 (arithmetic shift right) fills vacated high bits with src_i[31]. Carry is 1 exactly when src_i is negative and at least one 1-bit is shifted out; otherwise it is 0.
- R8: Op code 5 returns the number of leading zeros of src_i, from 0 to 32, with 32 for a zero input.
- R9: Op code 6 sign-extends src_i[7:0] and op code 7 sign-extends src_i[15:0] into the full word.
- R10: zero_o is 1 exactly when the registered result is 0, and neg_o equals bit 31 of the result. Carry is 0 for every op other than op code 4.
- R11: The outputs reflect the inputs sampled at the previous rising clock edge, with a latency of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 3 | Operation select (codes per R2 to R9) |
| src_i | input | 32 | Source word |
| dst_i | input | 32 | Destination word for insert |
| amt_sel_i | input | 1 | 1 selects the register amount, 0 selects the immediate |
| imm_amt_i | input | 5 | Immediate amount |
| reg_amt_i | input | 32 | Register amount; low 6 bits used |
| mb_i | input | 5 | Mask begin index (0 = most significant) |
| me_i | input | 5 | Mask end index (0 = most significant) |
| res_o | output | 32 | Registered result |
| carry_o | output | 1 | Carry from the arithmetic shift |
| zero_o | output | 1 | Result is zero |
| neg_o | output | 1 | Result is negative |

## Verification
Some properties are checked on every cycle. Carry may only rise after an arithmetic shift of a negative source. Logical shifts by 32 or more must give zero, and the arithmetic shift must give a sign-filled word. The leading-zero count must stay within 0 to 32. A sign-extended byte must show uniform upper bits, and the zero flag must agree with the result. Exact mask placement needs the bench's scenarios and its reference model: the most-significant-first indexing, the wrapped masks, the preserved destination bits on insert, and the exact position of rotated bits.

// File: rtl/rmsu_pkg.sv
// Shared definitions for the rotate-mask and shift unit.
package rmsu_pkg;
    typedef enum logic [2:0] {
        OP_ROTAND = 3'd0,
        OP_ROTINS = 3'd1,
        OP_SHL    = 3'd2,
        OP_SHR    = 3'd3,
        OP_SRA    = 3'd4,
        OP_CLZ    = 3'd5,
        OP_EXTB   = 3'd6,
        OP_EXTH   = 3'd7
    } rmsu_op_e;
endpackage

// File: rtl/rmsu_mask_gen.sv
// Builds a contiguous (possibly wrapping) mask from begin/end indices.
// Assumes indices count from the MSB: index 0 is bit W-1.
module rmsu_mask_gen #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [SW-1:0] mb_i,
    input  logic [SW-1:0] me_i,
    output logic [W-1:0]  mask_o
);
    logic wrap;
    assign wrap = (mb_i > me_i);

    // one decision per bit position
    for (genvar b = 0; b < W; b++) begin : g_bit
        localparam logic [SW-1:0] IDX = SW'(W - 1 - b);
        assign mask_o[b] = wrap ? ((IDX >= mb_i) || (IDX <= me_i))
                                : ((IDX >= mb_i) && (IDX <= me_i));
    end
endmodule

// File: rtl/rmsu_rotator.sv
// Logarithmic left rotator; amount taken modulo W.
// Assumes W is a power of two.
module rmsu_rotator #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  data_i,
    input  logic [SW-1:0] amt_i,
    output logic [W-1:0]  data_o
);
    logic [W-1:0] stage [SW+1];
    assign stage[0] = data_i;

    // stage s rotates by 2**s when amount bit s is set
    for (genvar s = 0; s < SW; s++) begin : g_stage
        localparam int D = 1 << s;
        assign stage[s+1] = amt_i[s]
            ? {stage[s][W-1-D:0], stage[s][W-1:W-D]}
            : stage[s];
    end

    assign data_o = stage[SW];
endmodule

// File: rtl/rmsu_clz.sv
// Counts leading zeros of a word; returns W for an all-zero word.
module rmsu_clz #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0] data_i,
    output logic [SW:0]  cnt_o
);
    // scan upward; the highest set bit is the last to update the count
    always_comb begin
        cnt_o = (SW+1)'(W);
        for (int i = 0; i < W; i++) begin
            if (data_i[i]) cnt_o = (SW+1)'(W - 1 - i);
        end
    end
endmodule

// File: rtl/rmsu_top.sv
// Rotate-mask and shift unit with one registered output stage.
// Assumes a synchronous active-low reset and W a power of two.
module rmsu_top #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    op_i,
    input  logic [W-1:0]  src_i,
    input  logic [W-1:0]  dst_i,
    input  logic          amt_sel_i,
    input  logic [SW-1:0] imm_amt_i,
    input  logic [W-1:0]  reg_amt_i,
    input  logic [SW-1:0] mb_i,
    input  logic [SW-1:0] me_i,
    output logic [W-1:0]  res_o,
    output logic          carry_o,
    output logic          zero_o,
    output logic          neg_o
);
    import rmsu_pkg::*;

    localparam int BW = 8;
    localparam int HW = 16;

    logic [SW:0]   amt;
    logic [W-1:0]  rot, mask, lost, nxt;
    logic [SW:0]   lz;
    logic          nxt_c;
    rmsu_op_e      op;

    assign op  = rmsu_op_e'(op_i);
    assign amt = amt_sel_i ? reg_amt_i[SW:0] : {1'b0, imm_amt_i};

    rmsu_rotator #(.W(W), .SW(SW)) u_rot (
        .data_i(src_i), .amt_i(amt[SW-1:0]), .data_o(rot));

    rmsu_mask_gen #(.W(W), .SW(SW)) u_mask (
        .mb_i(mb_i), .me_i(me_i), .mask_o(mask));

    rmsu_clz #(.W(W), .SW(SW)) u_clz (
        .data_i(src_i), .cnt_o(lz));

    // bits that an arithmetic right shift discards
    assign lost = src_i & ~({W{1'b1}} << amt);

    // select the next result and carry by operation
    always_comb begin
        nxt_c = 1'b0;
        unique case (op)
            OP_ROTAND: nxt = rot & mask;
            OP_ROTINS: nxt = (rot & mask) | (dst_i & ~mask);
            OP_SHL:    nxt = src_i << amt;
            OP_SHR:    nxt = src_i >> amt;
            OP_SRA: begin
                nxt   = W'($signed(src_i) >>> amt);
                nxt_c = src_i[W-1] && (|lost);
            end
            OP_CLZ:    nxt = W'(lz);
            OP_EXTB:   nxt = {{(W-BW){src_i[BW-1]}}, src_i[BW-1:0]};
            OP_EXTH:   nxt = {{(W-HW){src_i[HW-1]}}, src_i[HW-1:0]};
            default:   nxt = '0;
        endcase
    end

    // output register with flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_o   <= '0;
            carry_o <= 1'b0;
            zero_o  <= 1'b0;
            neg_o   <= 1'b0;
        end else begin
            res_o   <= nxt;
            carry_o <= nxt_c;
            zero_o  <= (nxt == '0);
            neg_o   <= nxt[W-1];
        end
    end
endmodule

// File: rtl/rmsu_chk.sv
// Checker for rmsu_top: relates registered outputs to sampled inputs.
module rmsu_chk #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    op_i,
    input logic [W-1:0]  src_i,
    input logic          amt_sel_i,
    input logic [W-1:0]  reg_amt_i,
    input logic [W-1:0]  res_o,
    input logic          carry_o,
    input logic          zero_o
);
    logic armed;

    // becomes 1 once the DUT has captured an input out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (res_o == '0 && !carry_o && !zero_o));

    p_carry_src_r7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        carry_o |-> ($past(op_i) == 3'd4 && $past(src_i[W-1])));

    p_wide_shl_zero_r5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(op_i) == 3'd2 && $past(amt_sel_i) && $past(reg_amt_i[SW]))
        |-> res_o == '0);

    p_wide_sra_fill_r5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(op_i) == 3'd4 && $past(amt_sel_i) && $past(reg_amt_i[SW]))
        |-> (res_o == '0 || res_o == '1));

    p_clz_range_r8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(op_i) == 3'd5) |-> res_o <= W);

    p_extb_upper_r9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(op_i) == 3'd6)
        |-> (res_o[W-1:7] == '0 || res_o[W-1:7] == '1));

    p_zero_flag_r10: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        zero_o == (res_o == '0));
endmodule

bind rmsu_top rmsu_chk #(.W(W), .SW(SW)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .src_i(src_i),
    .amt_sel_i(amt_sel_i), .reg_amt_i(reg_amt_i),
    .res_o(res_o), .carry_o(carry_o), .zero_o(zero_o));

// File: tb/rmsu_top_tb.sv
// Bench: behavioural reference model compared after every clock.
module rmsu_top_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  op;
    logic [31:0] src, dst, ramt;
    logic        sel;
    logic [4:0]  imm, mb, me;
    logic [31:0] res;
    logic        carry, zero, neg;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rmsu_top u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op), .src_i(src), .dst_i(dst),
        .amt_sel_i(sel), .imm_amt_i(imm), .reg_amt_i(ramt),
        .mb_i(mb), .me_i(me), .res_o(res), .carry_o(carry),
        .zero_o(zero), .neg_o(neg));

    function automatic logic [31:0] ref_rotl(logic [31:0] v, int n);
        logic [31:0] r = v;
        for (int k = 0; k < n; k++) r = {r[30:0], r[31]};
        return r;
    endfunction

    function automatic logic [31:0] ref_mask(int b, int e);
        logic [31:0] m = '0;
        for (int i = 0; i < 32; i++) begin
            bit in = (b <= e) ? (i >= b && i <= e) : (i >= b || i <= e);
            if (in) m[31 - i] = 1'b1;
        end
        return m;
    endfunction

    // reference result and carry for one input set
    task automatic ref_model(output logic [31:0] r, output logic c);
        int n = sel ? int'(ramt[5:0]) : int'(imm);
        logic [31:0] m = ref_mask(int'(mb), int'(me));
        logic [31:0] rt = ref_rotl(src, n % 32);
        c = 1'b0;
        r = '0;
        case (op)
            3'd0: r = rt & m;
            3'd1: r = (rt & m) | (dst & ~m);
            3'd2: for (int i = 0; i < 32; i++) if (i - n >= 0) r[i] = src[i - n];
            3'd3: for (int i = 0; i < 32; i++) if (i + n < 32) r[i] = src[i + n];
            3'd4: begin
                for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? src[i + n] : src[31];
                for (int i = 0; i < 32; i++) if (i < n && src[i] && src[31]) c = 1'b1;
            end
            3'd5: begin
                int z = 0;
                while (z < 32 && !src[31 - z]) z++;
                r = 32'(z);
            end
            3'd6: r = {{24{src[7]}}, src[7:0]};
            default: r = {{16{src[15]}}, src[15:0]};
        endcase
    endtask

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // drive at the falling edge, let one rising edge capture, compare at the next fall
    task automatic apply(string req, logic [2:0] o, logic [31:0] s, logic [31:0] d,
                         logic sl, logic [4:0] im, logic [31:0] ra,
                         logic [4:0] b, logic [4:0] e);
        logic [31:0] er;
        logic ec;
        op = o; src = s; dst = d; sel = sl; imm = im; ramt = ra; mb = b; me = e;
        ref_model(er, ec);
        @(posedge clk);
        @(negedge clk);
        check(req, "result", res, er);
        check(req, "carry", 32'(carry), 32'(ec));
        check("R10", "zero", 32'(zero), 32'(er == 0));
        check("R10", "neg", 32'(neg), 32'(er[31]));
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        op = 3'd2; src = 32'hFFFF_FFFF; dst = '0; sel = 0; imm = 0; ramt = 0; mb = 0; me = 31;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "reset result", res, 32'h0);
        check("R1", "reset carry", 32'(carry), 0);
        check("R1", "reset zero", 32'(zero), 0);
        rst_n = 1'b1;

        // R2: rotate 8, mask 24..31 -> low byte; amount 0 passes through
        apply("R2", 3'd0, 32'h1234_5678, 0, 0, 5'd8, 0, 5'd24, 5'd31);
        check("R2", "low byte", res, 32'h0000_0012);
        apply("R2", 3'd0, 32'hDEAD_BEEF, 0, 0, 5'd0, 0, 5'd0, 5'd31);
        check("R2", "passthrough", res, 32'hDEAD_BEEF);
        // R3: wrapping mask 28..3
        apply("R3", 3'd0, 32'hFFFF_FFFF, 0, 0, 5'd0, 0, 5'd28, 5'd3);
        check("R3", "wrap mask", res, 32'hF000_000F);
        // R4: insert a nibble
        apply("R4", 3'd1, 32'h0000_000A, 32'hFFFF_0000, 0, 5'd4, 0, 5'd24, 5'd27);
        check("R4", "insert", res, 32'hFFFF_00A0);
        // R5: register amount, high bits ignored, 32-weight bit
        apply("R5", 3'd2, 32'h0000_0001, 0, 1, 5'd0, 32'hFFFF_FFC4, 0, 31);
        check("R5", "low6 amount", res, 32'h0000_0010);
        apply("R5", 3'd2, 32'hFFFF_FFFF, 0, 1, 5'd0, 32'h24, 0, 31);
        check("R5", "wide shl", res, 32'h0);
        apply("R5", 3'd4, 32'h8000_0000, 0, 1, 5'd0, 32'h20, 0, 31);
        check("R5", "wide sra", res, 32'hFFFF_FFFF);
        check("R7", "wide sra carry", 32'(carry), 1);
        apply("R5", 3'd0, 32'h0000_0001, 0, 1, 5'd0, 32'h21, 0, 31);
        check("R5", "rotate mod 32", res, 32'h0000_0002);
        // R6: logical shifts
        apply("R6", 3'd3, 32'hF000_000F, 0, 0, 5'd4, 0, 0, 31);
        check("R6", "shr", res, 32'h0F00_0000);
        apply("R6", 3'd2, 32'hF000_000F, 0, 0, 5'd4, 0, 0, 31);
        check("R6", "shl", res, 32'h0000_00F0);
        // R7: arithmetic shift carry cases
        apply("R7", 3'd4, 32'hFFFF_FFF0, 0, 0, 5'd4, 0, 0, 31);
        check("R7", "no lost ones", 32'(carry), 0);
        apply("R7", 3'd4, 32'hFFFF_FFF1, 0, 0, 5'd4, 0, 0, 31);
        check("R7", "lost one", 32'(carry), 1);
        apply("R7", 3'd4, 32'h0000_0007, 0, 0, 5'd2, 0, 0, 31);
        check("R7", "positive", 32'(carry), 0);
        // R8: leading zeros
        apply("R8", 3'd5, 32'h0, 0, 0, 0, 0, 0, 31);
        check("R8", "zero input", res, 32);
        apply("R8", 3'd5, 32'h1, 0, 0, 0, 0, 0, 31);
        check("R8", "one", res, 31);
        apply("R8", 3'd5, 32'h8000_0000, 0, 0, 0, 0, 0, 31);
        check("R8", "msb", res, 0);
        // R9: sign extension
        apply("R9", 3'd6, 32'h1234_5680, 0, 0, 0, 0, 0, 31);
        check("R9", "byte", res, 32'hFFFF_FF80);
        apply("R9", 3'd7, 32'hFFFF_7FFF, 0, 0, 0, 0, 0, 31);
        check("R9", "half", res, 32'h0000_7FFF);

        // R11 / R10: random vectors, one per clock, compared against the model
        for (int k = 0; k < 400; k++) begin
            apply("R11", 3'($urandom), $urandom, $urandom, 1'($urandom),
                  5'($urandom), $urandom, 5'($urandom), 5'($urandom));
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule